// File: doc/BRIEF.md
# Reset Pin Digital Filter

This block conditions an external active-low reset pin before it may request a system reset. The pin is first brought into the bus-clock domain by a two-flop synchronizer. A digital filter then decides when the filtered level may follow the synchronized pin, and the block drives a single active-high reset request.

The filter is picked by static configuration inputs. Outside stop mode, one 2-bit selector applies to both run and wait modes. It chooses one of three options: no filtering, a bus-clock counter filter whose width comes from a programmable count, or a filter clocked by low-power oscillator ticks. The ticks arrive as a one-cycle enable strobe in the bus-clock domain. In stop mode the selector is ignored, and a separate enable bit decides whether the low-power tick filter is used or the pin passes unfiltered.

Both edges of the pin are filtered in the same way: the assertion of a reset request and its release. A single counter serves the bus-clock filter and the tick filter, because only one of them is ever active.

Top module: `rst_pin_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rst_req` is 0. The synchronizer and the filtered level reset to the released (high) pin state.
- R2: With filtering off, a `pin_n` level sampled at rising edge k appears on `rst_req` after rising edge k+2. That is three edges including the sampling edge.
- R3: Outside stop mode, `run_filt_sel` is decoded as 0 = off, 1 = bus-clock filter, 2 = tick filter, and 3 = off.
- R4: In bus-clock mode with count N = `bus_filt_cnt`, the output takes a new pin level only after the synchronized pin has differed from the output for N+1 consecutive clocks. A level held at the pin from edge k appears after edge k+N+2.
- R5: In bus-clock mode, a pin pulse shorter than N+1 clocks leaves `rst_req` unchanged, and the count restarts when the pin returns.
- R6: In tick mode, the output changes only on a cycle with `lp_tick` = 1, after the synchronized pin has differed from the output on 3 consecutive tick cycles. A return to the output level before that restarts the count. With `lp_tick` held at 1, a level sampled at edge k appears after edge k+4.
- R7: When `stop_mode` = 1, `stop_filt_en` = 1 selects the tick filter and `stop_filt_en` = 0 selects no filtering.
- R8: In stop mode, `run_filt_sel` has no effect. Outside bus-clock mode, `bus_filt_cnt` has no effect.
- R9: `rst_req` is 1 exactly when the filtered pin level is low.
- R10: The release of the pin (low to high) is filtered with the same rules and latency as its assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pin_n | input | 1 | External reset pin, active low, asynchronous |
| stop_mode | input | 1 | 1 while the chip is in stop mode |
| run_filt_sel | input | 2 | Run/wait filter select: 0 off, 1 bus clock, 2 ticks, 3 off |
| stop_filt_en | input | 1 | Stop-mode tick filter enable |
| bus_filt_cnt | input | CNT_W | Bus-clock filter count N; the hold time is N+1 clocks |
| lp_tick | input | 1 | One-cycle strobe per low-power oscillator tick |
| rst_req | output | 1 | Filtered reset request, active high |

## Verification
The hardest situation to reach from the ports is a configuration change or a pin glitch that arrives while the shared counter is part way through a hold window. In that case a stale count from one filter meets the limit of the other. The random phase changes the selector, the stop controls and the count every few hundred cycles without first waiting for the pin to settle. It toggles the pin sparsely and gives ticks a low duty cycle, so that partial windows are common when the configuration changes. A cycle-accurate bench model, built from the requirements, is compared with `rst_req` on every cycle. Directed cases measure the exact latency for each mode, the count limits 0 and maximum, short glitches, and both pin directions.

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int CNT_W   = 5,
  parameter int LP_HOLD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_n,
  input  logic             stop_mode,
  input  logic [1:0]       run_filt_sel,
  input  logic             stop_filt_en,
  input  logic [CNT_W-1:0] bus_filt_cnt,
  input  logic             lp_tick,
  output logic             rst_req
);
  localparam int LPW = $clog2(LP_HOLD + 1);
  localparam int CW  = (CNT_W > LPW) ? CNT_W : LPW;
  localparam logic [1:0] SEL_BUS = 2'd1;
  localparam logic [1:0] SEL_LP  = 2'd2;

  logic [1:0]    sync_q;
  logic          pin_s;
  logic          filt_q;
  logic [CW-1:0] cnt_q;
  logic          use_bus, use_lp, differ, bus_done, lp_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_n};

  assign pin_s    = sync_q[1];
  assign use_lp   = stop_mode ? stop_filt_en : (run_filt_sel == SEL_LP);
  assign use_bus  = !stop_mode && (run_filt_sel == SEL_BUS);
  assign differ   = pin_s ^ filt_q;
  assign bus_done = cnt_q >= CW'(bus_filt_cnt);
  assign lp_done  = cnt_q >= CW'(LP_HOLD - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (!use_bus && !use_lp) begin
      filt_q <= pin_s;
      cnt_q  <= '0;
    end else if (!differ) begin
      cnt_q  <= '0;
    end else if (use_bus) begin
      if (bus_done) begin
        filt_q <= pin_s;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end else if (lp_tick) begin
      if (lp_done) begin
        filt_q <= pin_s;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end

  assign rst_req = ~filt_q;
endmodule

module rst_pin_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_mode,
  input logic [1:0] run_filt_sel,
  input logic       stop_filt_en,
  input logic       lp_tick,
  input logic       pin_s,
  input logic       filt_q,
  input logic       rst_req
);
  logic off_cfg, bus_cfg, lp_run_cfg, lp_stop_cfg;
  assign off_cfg     = stop_mode ? !stop_filt_en : (run_filt_sel == 2'd0 || run_filt_sel == 2'd3);
  assign bus_cfg     = !stop_mode && run_filt_sel == 2'd1;
  assign lp_run_cfg  = !stop_mode && run_filt_sel == 2'd2;
  assign lp_stop_cfg = stop_mode && stop_filt_en;

  assert_off_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    off_cfg |=> (filt_q == $past(pin_s)));

  assert_change_toward_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(pin_s)));

  assert_bus_no_change_when_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cfg && pin_s == filt_q) |=> $stable(filt_q));

  assert_lp_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_run_cfg && !lp_tick) |=> $stable(filt_q));

  assert_stop_lp_only_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_stop_cfg && !lp_tick) |=> $stable(filt_q));

  assert_req_changes_with_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> rst_req);
endmodule

bind rst_pin_filter rst_pin_filter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_mode    (stop_mode),
  .run_filt_sel (run_filt_sel),
  .stop_filt_en (stop_filt_en),
  .lp_tick      (lp_tick),
  .pin_s        (pin_s),
  .filt_q       (filt_q),
  .rst_req      (rst_req)
);

// File: tb/tb_rst_pin_filter.sv
`timescale 1ns/1ps
module tb_rst_pin_filter;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pin_n = 1'b1;
  logic             stop_mode = 1'b0;
  logic [1:0]       run_filt_sel = 2'd0;
  logic             stop_filt_en = 1'b0;
  logic [CNT_W-1:0] bus_filt_cnt = '0;
  logic             lp_tick = 1'b0;
  logic             rst_req;

  int checks = 0;
  int failures = 0;

  logic m_s1 = 1'b1, m_s2 = 1'b1, m_out = 1'b1;
  int   m_cnt = 0;

  always #5 clk = ~clk;

  rst_pin_filter #(.CNT_W(CNT_W), .LP_HOLD(3)) dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .stop_mode(stop_mode),
    .run_filt_sel(run_filt_sel), .stop_filt_en(stop_filt_en),
    .bus_filt_cnt(bus_filt_cnt), .lp_tick(lp_tick), .rst_req(rst_req)
  );

  // 0 = off, 1 = bus-clock filter, 2 = tick filter (R3, R7)
  function automatic int eff_mode();
    if (stop_mode) return stop_filt_en ? 2 : 0;
    if (run_filt_sel == 2'd1) return 1;
    if (run_filt_sel == 2'd2) return 2;
    return 0;
  endfunction

  function automatic string mode_tag();
    if (stop_mode) return "R7";
    case (eff_mode())
      1: return "R4";
      2: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s rst_req act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic held;
    held = (m_s2 != m_out);
    case (eff_mode())
      0: begin m_out = m_s2; m_cnt = 0; end
      1: if (!held) m_cnt = 0;
         else if (m_cnt >= int'(bus_filt_cnt)) begin m_out = m_s2; m_cnt = 0; end
         else m_cnt++;
      default: if (!held) m_cnt = 0;
         else if (lp_tick) begin
           if (m_cnt >= 2) begin m_out = m_s2; m_cnt = 0; end
           else m_cnt++;
         end
    endcase
    m_s2 = m_s1;
    m_s1 = pin_n;
  endtask

  task automatic step();
    string tag;
    tag = mode_tag();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, rst_req, ~m_out);
  endtask

  task automatic latency(input string tag, input logic lvl, input int exp_edges);
    logic start;
    int n;
    start = rst_req;
    pin_n = lvl;
    n = 0;
    for (int i = 0; i < 80; i++) begin
      step();
      n++;
      if (rst_req != start) break;
    end
    checks++;
    if (n != exp_edges) begin
      failures++;
      $display("FAIL %s latency act=%0d exp=%0d", tag, n, exp_edges);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      check("R1", rst_req, 1'b0);
    end
    pin_n = 1'b0;
    @(negedge clk);
    check("R1", rst_req, 1'b0);
    pin_n = 1'b1;
    rst_n = 1'b1;
    step();
    check("R1", rst_req, 1'b0);

    // R2 off mode latency, R10 release
    lp_tick = 1'b1;
    latency("R2", 1'b0, 3);
    check("R9", rst_req, 1'b1);
    latency("R10", 1'b1, 3);
    check("R9", rst_req, 1'b0);

    // R3 selector value 3 is off; R8 count unused
    run_filt_sel = 2'd3; bus_filt_cnt = 5'd20;
    settle(4);
    latency("R3", 1'b0, 3);
    latency("R3", 1'b1, 3);

    // R4 bus-clock filter at N = 0, 5 and maximum
    run_filt_sel = 2'd1;
    bus_filt_cnt = 5'd0;  settle(4);
    latency("R4", 1'b0, 3);
    latency("R10", 1'b1, 3);
    bus_filt_cnt = 5'd5;  settle(8);
    latency("R4", 1'b0, 8);
    latency("R10", 1'b1, 8);
    bus_filt_cnt = 5'd31; settle(40);
    latency("R4", 1'b0, 34);
    latency("R10", 1'b1, 34);

    // R5 glitch of N clocks ignored, then full hold accepted
    bus_filt_cnt = 5'd5; settle(10);
    pin_n = 1'b0; settle(5);
    pin_n = 1'b1; settle(12);
    check("R5", rst_req, 1'b0);
    pin_n = 1'b0; settle(4);
    pin_n = 1'b1; settle(1);
    pin_n = 1'b0; settle(5);
    check("R5", rst_req, 1'b0);
    settle(10);
    check("R5", rst_req, 1'b1);
    pin_n = 1'b1; settle(12);

    // R6 tick filter
    run_filt_sel = 2'd2; lp_tick = 1'b1; settle(6);
    latency("R6", 1'b0, 5);
    latency("R10", 1'b1, 5);
    lp_tick = 1'b0;
    pin_n = 1'b0; settle(30);
    check("R6", rst_req, 1'b0);
    for (int k = 0; k < 3; k++) begin
      lp_tick = 1'b1; step(); lp_tick = 1'b0; settle(6);
    end
    check("R6", rst_req, 1'b1);
    pin_n = 1'b1; settle(3);
    lp_tick = 1'b1; step(); step(); lp_tick = 1'b0;
    pin_n = 1'b0; settle(4);
    pin_n = 1'b1; settle(3);
    lp_tick = 1'b1; step(); lp_tick = 1'b0; settle(3);
    check("R6", rst_req, 1'b1);
    lp_tick = 1'b1; settle(4);
    check("R6", rst_req, 1'b0);

    // R7 / R8 stop mode
    stop_mode = 1'b1; stop_filt_en = 1'b0; run_filt_sel = 2'd1; bus_filt_cnt = 5'd10;
    settle(4);
    latency("R8", 1'b0, 3);
    latency("R8", 1'b1, 3);
    stop_filt_en = 1'b1; run_filt_sel = 2'd0; settle(4);
    latency("R7", 1'b0, 5);
    latency("R7", 1'b1, 5);

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 6000; c++) begin
      if (c % 250 == 0) begin
        stop_mode    = ($urandom % 4) == 0;
        stop_filt_en = $urandom % 2;
        run_filt_sel = 2'($urandom % 4);
        bus_filt_cnt = CNT_W'($urandom % 12);
      end
      if (($urandom % 9) == 0) pin_n = ~pin_n;
      lp_tick = ($urandom % 3) == 0;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule